// File: doc/BRIEF.md
# Oversampled Serial Start-Bit Validator

This block sits at the front of an asynchronous serial receiver. It runs on a 16x oversampling tick. While idle it watches the received line, after a two-flop synchroniser, for a high-to-low transition. When it sees one, it counts sixteen ticks of one bit time. Over that bit time it reads the line at six fixed phases, grouped into two windows of three. Each window is judged by how many of its samples read low. From that judgement the block either accepts the start bit cleanly, accepts it with a noise indication, or quietly drops back to idle.

When a start bit is accepted, the block issues a one-cycle start pulse. A noise pulse comes in the same cycle if the bit was marginal. At the end of the bit time it issues a one-cycle bit-boundary pulse. A downstream data-bit sampler uses that pulse to lock its own tick count to the frame. That sampler drives a busy input while it is receiving the rest of the frame, and the validator ignores the line until busy falls.

Top module: `rx_start_gate`

## Requirements
- R1: The line passes through a two-flop synchroniser, and the synchronised value is re-read on each oversampling tick. A start-bit check begins only in idle, on a tick where the previous tick's reading was 1 and the current one is 0. A low pulse that falls entirely between two ticks starts nothing.
- R2: The edge tick is phase 1 of the bit time. The first window reads the line at phases 3, 5 and 7, and the second window at phases 8, 9 and 10. Line values at every other phase have no effect on the outcome, and a new falling edge during the check does not restart it.
- R3: If all six samples read 0, `start_ok` pulses and `noise_flag` stays low.
- R4: If each window has at least two of its three samples at 0, but the six are not all 0, `start_ok` and `noise_flag` pulse together.
- R5: If either window has fewer than two samples at 0, the check aborts. Neither pulse is issued, no bit-boundary pulse follows, and the block returns to idle to wait for a new falling edge.
- R6: `start_ok` and `noise_flag` are single-cycle pulses. They rise one clock after the phase-10 tick.
- R7: After an accepted start bit, `bit_edge` pulses for one clock, one clock after the phase-16 tick. The block is then idle.
- R8: While `busy` is high in idle, falling edges are ignored. After `busy` falls, a new high-to-low transition is needed before a check begins.
- R9: A synchronous active-high reset returns the block to idle with all outputs low and the line treated as high. A check in progress when reset arrives is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-clock strobe at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| busy | input | 1 | High while the downstream sampler is receiving a frame |
| start_ok | output | 1 | One-cycle pulse: start bit accepted |
| noise_flag | output | 1 | One-cycle pulse with start_ok when the start bit was marginal |
| bit_edge | output | 1 | One-cycle pulse at the end of the accepted start bit |

## Verification
The bench drives the line phase by phase and checks every output after every tick. It covers the boundary between two and one low samples in each window separately, and the case where both windows hold exactly two. A design that counted the windows together, or swapped the noise and abort rules, would accept frames that should abort or drop frames that should raise noise. High values placed at the unsampled phases expose a design that reads the wrong phase or that restarts on the later falling edge; such a design would shift or lose the start pulse. Separate scenarios cover a sub-tick glitch, an edge arriving while busy with the line still low after busy falls, and a reset in the middle of a check. These catch designs that sample edges off-tick, latch a pending edge, or keep stale counter state.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HUNT  = 2'd1,
    ST_ALIGN = 2'd2
  } rsg_state_e;

  // six sample phases, zero-based (phase 1 = edge tick = index 0)
  localparam int unsigned N_SMP = 6;
  localparam int unsigned WIN   = 3;
  localparam int unsigned SMP_IDX [N_SMP] = '{2, 4, 6, 7, 8, 9};
  localparam int unsigned EVAL_IDX = SMP_IDX[N_SMP-1];

  function automatic logic [1:0] zeros3(input logic [WIN-1:0] v);
    return 2'($countones(~v));
  endfunction

endpackage

// File: rtl/rsg_sync.sv
module rsg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rx_async,
  output logic rx_s,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], rx_async};
  end

  assign rx_s = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)       prev_q <= 1'b1;
    else if (tick) prev_q <= rx_s;
  end

  assign fall = tick & prev_q & ~rx_s;

endmodule

// File: rtl/rsg_phase.sv
module rsg_phase #(
  parameter int unsigned OSR = 16,
  localparam int unsigned PW = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] phase_q,
  output logic [PW-1:0] phase_nx
);

  assign phase_nx = phase_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) phase_q <= '0;
    else if (adv)   phase_q <= phase_nx;
  end

endmodule

// File: rtl/rsg_vote.sv
module rsg_vote
  import rsg_pkg::*;
#(
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [PW-1:0] phase_nx,
  input  logic          rx,
  output logic          accept,
  output logic          clean
);

  logic [N_SMP-1:0] smp_q;
  logic [N_SMP-1:0] live;
  logic [1:0]       z_a, z_b;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      smp_q <= '1;
    end else if (adv) begin
      for (int i = 0; i < int'(N_SMP); i++) begin
        if (phase_nx == PW'(SMP_IDX[i])) smp_q[i] <= rx;
      end
    end
  end

  // the sample taken on the current tick is used directly
  for (genvar g = 0; g < int'(N_SMP); g++) begin : g_live
    assign live[g] = (phase_nx == PW'(SMP_IDX[g])) ? rx : smp_q[g];
  end

  assign z_a    = zeros3(live[WIN-1:0]);
  assign z_b    = zeros3(live[N_SMP-1:WIN]);
  assign accept = (z_a >= 2'd2) && (z_b >= 2'd2);
  assign clean  = (z_a == 2'd3) && (z_b == 2'd3);

endmodule

// File: rtl/rx_start_gate.sv
module rx_start_gate
  import rsg_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic os_tick,
  input  logic rx_line,
  input  logic busy,
  output logic start_ok,
  output logic noise_flag,
  output logic bit_edge
);

  localparam int unsigned PW = $clog2(OSR);

  rsg_state_e    state;
  logic          rx_s, fall;
  logic          in_idle, adv;
  logic [PW-1:0] phase_q, phase_nx;
  logic          accept, clean;

  assign in_idle = (state == ST_IDLE);
  assign adv     = os_tick && !in_idle;

  rsg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .tick(os_tick), .rx_async(rx_line),
    .rx_s(rx_s), .fall(fall)
  );

  rsg_phase #(.OSR(OSR)) u_phase (
    .clk(clk), .rst(rst), .clr(in_idle), .adv(adv),
    .phase_q(phase_q), .phase_nx(phase_nx)
  );

  rsg_vote #(.PW(PW)) u_vote (
    .clk(clk), .rst(rst), .clr(in_idle), .adv(adv),
    .phase_nx(phase_nx), .rx(rx_s),
    .accept(accept), .clean(clean)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      start_ok   <= 1'b0;
      noise_flag <= 1'b0;
      bit_edge   <= 1'b0;
    end else begin
      start_ok   <= 1'b0;
      noise_flag <= 1'b0;
      bit_edge   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fall && !busy) state <= ST_HUNT;
        end
        ST_HUNT: begin
          if (os_tick && phase_nx == PW'(EVAL_IDX)) begin
            if (accept) begin
              state      <= ST_ALIGN;
              start_ok   <= 1'b1;
              noise_flag <= !clean;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ALIGN: begin
          if (os_tick && phase_nx == PW'(OSR-1)) begin
            bit_edge <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_start_gate_chk.sv
module rx_start_gate_chk
  import rsg_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       os_tick,
  input logic       busy,
  input logic       start_ok,
  input logic       noise_flag,
  input logic       bit_edge,
  input rsg_state_e state
);

  logic [7:0] ticks_since;

  always_ff @(posedge clk) begin
    if (rst)           ticks_since <= '0;
    else if (start_ok) ticks_since <= {7'd0, os_tick};
    else if (os_tick)  ticks_since <= ticks_since + 8'd1;
  end

  assert_noise_with_start_R4: assert property (@(posedge clk) disable iff (rst)
    noise_flag |-> start_ok);

  assert_start_single_R6: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> !start_ok);

  assert_start_after_tick_R6: assert property (@(posedge clk) disable iff (rst)
    start_ok |-> $past(os_tick));

  assert_edge_after_tick_R7: assert property (@(posedge clk) disable iff (rst)
    bit_edge |-> $past(os_tick));

  assert_edge_phase_R7: assert property (@(posedge clk) disable iff (rst)
    bit_edge |-> (ticks_since == 8'(OSR - 1 - EVAL_IDX)));

  assert_busy_holds_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && busy) |=> (state == ST_IDLE));

endmodule

bind rx_start_gate rx_start_gate_chk #(.OSR(OSR)) u_chk (
  .clk(clk), .rst(rst), .os_tick(os_tick), .busy(busy),
  .start_ok(start_ok), .noise_flag(noise_flag), .bit_edge(bit_edge),
  .state(state)
);

// File: tb/rx_start_gate_test.sv
module rx_start_gate_test;

  logic clk = 1'b0;
  logic rst, os_tick, rx_line, busy;
  logic start_ok, noise_flag, bit_edge;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  rx_start_gate uut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_line(rx_line), .busy(busy),
    .start_ok(start_ok), .noise_flag(noise_flag), .bit_edge(bit_edge)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // drive one line value, then deliver one tick; returns just after the
  // edge that registers the tick's result
  task automatic step(input logic v);
    @(negedge clk); rx_line = v; os_tick = 1'b0;
    repeat (2) @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk); os_tick = 1'b0;
  endtask

  // w[p-1] is the line at phase p; a/b are the window samples (1 = high)
  function automatic logic [15:0] pat(input logic [2:0] a, input logic [2:0] b,
                                      input logic oth, input logic tail);
    logic [15:0] w;
    w[0] = 1'b0; w[1] = oth; w[2] = a[0]; w[3] = oth; w[4] = a[1];
    w[5] = oth;  w[6] = a[2]; w[7] = b[0]; w[8] = b[1]; w[9] = b[2];
    w[15:10] = {6{tail}};
    return w;
  endfunction

  task automatic run_frame(input logic [15:0] w, input logic eok, input logic enoise,
                           input string req);
    repeat (3) step(1'b1);
    for (int p = 1; p <= 16; p++) begin
      step(w[p-1]);
      chk(req, $sformatf("start_ok phase %0d", p), start_ok, (p == 10) && eok);
      chk(req, $sformatf("noise_flag phase %0d", p), noise_flag, (p == 10) && enoise);
      chk(req, $sformatf("bit_edge phase %0d", p), bit_edge, (p == 16) && eok);
    end
  endtask

  task automatic quiet_steps(input logic v, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      step(v);
      chk(req, "start_ok quiet", start_ok, 1'b0);
      chk(req, "noise_flag quiet", noise_flag, 1'b0);
      chk(req, "bit_edge quiet", bit_edge, 1'b0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9", "start_ok in reset", start_ok, 1'b0);
    chk("R9", "noise_flag in reset", noise_flag, 1'b0);
    chk("R9", "bit_edge in reset", bit_edge, 1'b0);
    rst = 1'b0;
    quiet_steps(1'b1, 4, "R9");
  endtask

  task automatic t_clean;
    run_frame(pat(3'b000, 3'b000, 1'b0, 1'b0), 1'b1, 1'b0, "R3");
    run_frame(pat(3'b000, 3'b000, 1'b0, 1'b1), 1'b1, 1'b0, "R7");
  endtask

  task automatic t_unsampled;
    // highs at phases 2,4,6 make new falling edges mid-check
    run_frame(pat(3'b000, 3'b000, 1'b1, 1'b1), 1'b1, 1'b0, "R2");
  endtask

  task automatic t_noise;
    run_frame(pat(3'b100, 3'b000, 1'b0, 1'b0), 1'b1, 1'b1, "R4");
    run_frame(pat(3'b000, 3'b010, 1'b0, 1'b0), 1'b1, 1'b1, "R4");
    run_frame(pat(3'b001, 3'b100, 1'b1, 1'b0), 1'b1, 1'b1, "R4");
  endtask

  task automatic t_abort;
    run_frame(pat(3'b110, 3'b000, 1'b1, 1'b1), 1'b0, 1'b0, "R5");
    run_frame(pat(3'b000, 3'b111, 1'b0, 1'b1), 1'b0, 1'b0, "R5");
    run_frame(pat(3'b101, 3'b101, 1'b1, 1'b1), 1'b0, 1'b0, "R5");
    run_frame(pat(3'b000, 3'b000, 1'b0, 1'b0), 1'b1, 1'b0, "R5");
    chk("R6", "start_ok drops after pulse", start_ok, 1'b0);
  endtask

  task automatic t_glitch;
    quiet_steps(1'b1, 2, "R1");
    @(negedge clk); rx_line = 1'b0;
    @(negedge clk); rx_line = 1'b1;
    quiet_steps(1'b1, 16, "R1");
  endtask

  task automatic t_busy;
    busy = 1'b1;
    quiet_steps(1'b1, 3, "R8");
    quiet_steps(1'b0, 16, "R8");
    busy = 1'b0;
    quiet_steps(1'b0, 4, "R8");
    run_frame(pat(3'b000, 3'b000, 1'b0, 1'b0), 1'b1, 1'b0, "R8");
  endtask

  task automatic t_reset_mid;
    quiet_steps(1'b1, 3, "R9");
    step(1'b0); step(1'b0); step(1'b0);
    @(negedge clk); rst = 1'b1; rx_line = 1'b1;
    @(negedge clk);
    chk("R9", "start_ok after mid reset", start_ok, 1'b0);
    rst = 1'b0;
    quiet_steps(1'b1, 16, "R9");
    run_frame(pat(3'b000, 3'b000, 1'b0, 1'b0), 1'b1, 1'b0, "R9");
  endtask

  initial begin
    rst = 1'b1; os_tick = 1'b0; rx_line = 1'b1; busy = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_clean();
    t_unsampled();
    t_noise();
    t_abort();
    t_glitch();
    t_busy();
    t_reset_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule